// File: doc/BRIEF.md
# SPI Serial Byte-Memory Slave

This block is an SPI slave that fronts a byte-addressed memory held in an internal synthesizable array. The default is 8192 bytes, stored as 2048 rows of four bytes. The bus master opens an operation by pulling chip select low. It then shifts in a one-byte command and, for memory commands, a two-byte start address. After that, data bytes flow into or out of the array, and the address steps by one after each byte. A write lands in the array as soon as the eighth bit of its byte has arrived. There is no page buffer and no busy state.

The SPI pins are sampled by a system clock that runs at least four times faster than SCK, through two-flop synchronisers. Both idle clock levels are accepted: idle low with sampling on the rising edge, and idle high with the first edge a falling one. A pause input freezes the transfer at the current bit. An eight-bit control byte holds a write-enable flag, two block-guard bits and a guard-lock bit. The decision whether a write may land is made by an external protection unit. The block raises a one-cycle request that carries the target (array or control byte) and the address, and the unit answers in the same cycle with a grant.

SPI has no back-pressure, so the serial stream carries no valid/ready handshake. The array accepts a write strobe and a read-prefetch request on any cycle.

Top module: `spi_nvram_slave`

## Requirements
- R1: Command bytes are sent MSB first. 06h sets the write-enable flag and 04h clears it. 05h shifts out the control byte, MSB first: bit 7 guard-lock, bits 6:4 zero, bits 3:2 block-guard, bit 1 write-enable, bit 0 zero.
- R2: Only the first byte after chip select falls is decoded as a command. After 06h, 04h or an unknown code, every further byte is ignored until chip select rises, and `so_oe` stays low.
- R3: 02h (write) and 03h (read) take a two-byte address, high byte first. Only the low ADDR_W bits are used, so address E005h reaches byte 0005h.
- R4: A read returns bytes from consecutive addresses with no length limit. After the top address (1FFFh by default) it wraps to 0000h. Data bits on SI after the address are ignored.
- R5: During a write, each completed byte is stored at the current address, and the address then steps with the same wrap. The store happens only when the write-enable flag is set. A byte cut short by chip select rising is discarded.
- R6: 01h shifts in one byte. Only bits 7, 3 and 2 of it are taken into the control byte, and only when the write-enable flag is set.
- R7: When chip select rises after an accepted 02h or 01h command, the write-enable flag is cleared, whether or not any byte was stored.
- R8: Each completed data byte of 02h or 01h raises `prot_req` for exactly one cycle. With it, `prot_req_sr` is 1 for the control byte and `prot_req_addr` gives the array address. No store happens when `prot_grant` is low in that cycle.
- R9: SO changes only after a falling SCK. It is enabled only during the data phase of 03h or 05h, with chip select low and no pause in force.
- R10: A transfer that starts with SCK idle high behaves the same as one that starts with SCK idle low.
- R11: With the pause input low, which is taken while SCK is low, SCK edges are ignored and SO is disabled. After release, the transfer resumes at the same bit.
- R12: After reset the control byte reads 00h and `so_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO (tri-state control) |
| prot_req | output | 1 | Write permission request, one cycle per data byte |
| prot_req_sr | output | 1 | Request targets the control byte |
| prot_req_addr | output | ADDR_W | Array address of the requested write |
| prot_grant | input | 1 | Same-cycle permission from the protection unit |
| status_o | output | 8 | Current control byte |

## Verification
The assertions assume the SCK, chip select and pause inputs each stay stable for several system clocks. Under that assumption every synchronised edge is seen exactly once, and a pause level is taken only while SCK reads low. They also assume that chip select does not move in the same few clocks as an SCK edge. The bench keeps SCK half periods at six system clocks and leaves a full half period between chip select and the nearest SCK edge. It changes the pause input only while SCK is low. Its random bursts come from a fixed seed and mix both idle clock levels.

// File: rtl/spi_nvram_pkg.sv
package spi_nvram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA, ST_SRIN, ST_SROUT, ST_DONE
  } ph_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
endpackage

// File: rtl/spi_nvram_sync.sv
module spi_nvram_sync #(
  parameter int          N       = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] meta_q;

  // two flops per input bit, all bits delayed equally so data stays aligned with SCK
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end
endmodule

// File: rtl/spi_nvram_array.sv
module spi_nvram_array #(
  parameter int ADDR_W = 13,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int ROW_W  = ADDR_W - LANE_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int WORD_W = 8 << LANE_W;

  logic [WORD_W-1:0] mem [ROWS];
  logic [WORD_W-1:0] rword_q;
  logic [LANE_W-1:0] rlane_q;
  logic [LANE_W+2:0] wbit, rbit;

  assign wbit = {waddr[LANE_W-1:0], 3'b000};
  assign rbit = {rlane_q, 3'b000};

  always_ff @(posedge clk) begin
    if (we) mem[waddr[ADDR_W-1:LANE_W]][wbit +: 8] <= wdata;
    if (re) begin
      rword_q <= mem[raddr[ADDR_W-1:LANE_W]];
      rlane_q <= raddr[LANE_W-1:0];
    end
  end

  assign rdata = rword_q[rbit +: 8];
endmodule

// File: rtl/spi_nvram_ctrl.sv
module spi_nvram_ctrl
  import spi_nvram_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_s,
  input  logic              si_s,
  input  logic              hold_s,
  input  logic              prot_grant,
  input  logic [7:0]        mem_rdata,
  output logic              prot_req,
  output logic              prot_req_sr,
  output logic [ADDR_W-1:0] prot_req_addr,
  output logic [7:0]        status_o,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              so,
  output logic              so_oe,
  output ph_e               state,
  output logic [2:0]        bit_cnt,
  output logic              hold_act,
  output logic              wr_seen
);
  localparam logic [ADDR_W-1:0] ONE = 1;

  logic              act, rise, fall, byte_done, wr_byte, commit;
  logic [7:0]        byte_nxt, sh_in, out_sh, src;
  logic [ADDR_W-1:0] addr, start_addr;
  logic [ADDR_W-9:0] hi_q;
  logic              hi_done, is_rd, wel, lock_q;
  logic [1:0]        guard_q;
  logic [2:0]        ocnt;

  assign act        = !cs_s && !hold_act;
  assign rise       = act && sck_rise;
  assign fall       = act && sck_fall;
  assign byte_nxt   = {sh_in[6:0], si_s};
  assign byte_done  = rise && (bit_cnt == 3'd7);
  assign start_addr = {hi_q, byte_nxt};

  assign wr_byte       = byte_done && (state == ST_WDATA || state == ST_SRIN);
  assign prot_req      = wr_byte;
  assign prot_req_sr   = (state == ST_SRIN);
  assign prot_req_addr = addr;
  assign commit        = wr_byte && wel && prot_grant;

  assign mem_we    = commit && (state == ST_WDATA);
  assign mem_waddr = addr;
  assign mem_wdata = byte_nxt;

  // prefetch: first byte when the address completes, next byte when a read byte completes
  assign mem_re    = byte_done && ((state == ST_ADDR && hi_done && is_rd) || state == ST_RDATA);
  assign mem_raddr = (state == ST_ADDR) ? start_addr : addr + ONE;

  assign status_o = {lock_q, 3'b000, guard_q, wel, 1'b0};
  assign src      = (state == ST_SROUT) ? status_o : mem_rdata;
  assign so_oe    = !cs_s && !hold_act && (state == ST_RDATA || state == ST_SROUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sh_in    <= '0;
      addr     <= '0;
      hi_q     <= '0;
      hi_done  <= 1'b0;
      is_rd    <= 1'b0;
      wr_seen  <= 1'b0;
      wel      <= 1'b0;
      lock_q   <= 1'b0;
      guard_q  <= '0;
      ocnt     <= '0;
      out_sh   <= '0;
      so       <= 1'b0;
      hold_act <= 1'b0;
    end else begin
      if (!sck_s) hold_act <= !hold_s;
      if (cs_s) begin
        if (wr_seen) wel <= 1'b0;
        wr_seen <= 1'b0;
        state   <= ST_IDLE;
        bit_cnt <= '0;
        ocnt    <= '0;
        hi_done <= 1'b0;
      end else begin
        if (state == ST_IDLE) state <= ST_OPC;
        if (rise) begin
          sh_in   <= byte_nxt;
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done) begin
          unique case (state)
            ST_OPC: begin
              unique case (byte_nxt)
                OP_WREN:  begin wel <= 1'b1; state <= ST_DONE; end
                OP_WRDI:  begin wel <= 1'b0; state <= ST_DONE; end
                OP_RDSR:  state <= ST_SROUT;
                OP_WRSR:  begin state <= ST_SRIN; wr_seen <= 1'b1; end
                OP_READ:  begin state <= ST_ADDR; is_rd <= 1'b1; end
                OP_WRITE: begin state <= ST_ADDR; is_rd <= 1'b0; wr_seen <= 1'b1; end
                default:  state <= ST_DONE;
              endcase
            end
            ST_ADDR: begin
              if (!hi_done) begin
                hi_q    <= byte_nxt[ADDR_W-9:0];
                hi_done <= 1'b1;
              end else begin
                addr  <= start_addr;
                state <= is_rd ? ST_RDATA : ST_WDATA;
              end
            end
            ST_WDATA, ST_RDATA: addr <= addr + ONE;
            ST_SRIN: begin
              if (commit) begin
                lock_q  <= byte_nxt[7];
                guard_q <= byte_nxt[3:2];
              end
              state <= ST_DONE;
            end
            ST_SROUT: state <= ST_DONE;
            default: ;
          endcase
        end
        if (fall && (state == ST_RDATA || state == ST_SROUT)) begin
          if (ocnt == 3'd0) begin
            so     <= src[7];
            out_sh <= {src[6:0], 1'b0};
          end else begin
            so     <= out_sh[7];
            out_sh <= {out_sh[6:0], 1'b0};
          end
          ocnt <= ocnt + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_nvram_slave.sv
module spi_nvram_slave
  import spi_nvram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic              prot_req,
  output logic              prot_req_sr,
  output logic [ADDR_W-1:0] prot_req_addr,
  input  logic              prot_grant,
  output logic [7:0]        status_o
);
  logic [3:0]        sync_q;
  logic              sck_s, cs_s, si_s, hold_s, sck_d, sck_rise, sck_fall;
  logic              mem_we, mem_re, hold_act, wr_seen;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic [2:0]        bit_cnt;
  ph_e               state;

  spi_nvram_sync #(.N(4), .RST_VAL(4'b1010)) sync_i (
    .clk(clk), .rst_n(rst_n), .din({hold_n, si, cs_n, sck}), .dout(sync_q)
  );
  assign {hold_s, si_s, cs_s, sck_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end
  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;

  spi_nvram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_s(cs_s), .si_s(si_s), .hold_s(hold_s), .prot_grant(prot_grant),
    .mem_rdata(mem_rdata), .prot_req(prot_req), .prot_req_sr(prot_req_sr),
    .prot_req_addr(prot_req_addr), .status_o(status_o), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .so(so), .so_oe(so_oe), .state(state),
    .bit_cnt(bit_cnt), .hold_act(hold_act), .wr_seen(wr_seen)
  );

  spi_nvram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) array_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/spi_nvram_chk.sv
module spi_nvram_chk
  import spi_nvram_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       hold_act,
  input logic       sck_fall,
  input logic       so,
  input logic       so_oe,
  input logic       prot_req,
  input logic       wr_seen,
  input logic [7:0] status_o,
  input ph_e        state,
  input logic [2:0] bit_cnt
);
  a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    prot_req |=> !prot_req);

  a_r7_wel_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) && wr_seen |=> !status_o[1]);

  a_r11_pause_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act && !cs_s |=> $stable(bit_cnt));

  a_r9_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe && $past(so_oe) && !$past(sck_fall) |-> $stable(so));

  a_r2_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DONE && !cs_s |=> state == ST_DONE);
endmodule

bind spi_nvram_slave spi_nvram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .hold_act(hold_act), .sck_fall(sck_fall),
  .so(so), .so_oe(so_oe), .prot_req(prot_req), .wr_seen(wr_seen),
  .status_o(status_o), .state(state), .bit_cnt(bit_cnt)
);

// File: tb/spi_nvram_slave_tb_top.sv
module spi_nvram_slave_tb_top;
  localparam int H = 120;
  localparam logic [7:0] C_WREN = 8'h06, C_WRDI = 8'h04, C_RDSR = 8'h05,
                         C_WRSR = 8'h01, C_READ = 8'h03, C_WRITE = 8'h02;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic prot_grant = 1'b1;
  logic so, so_oe, prot_req, prot_req_sr;
  logic [12:0] prot_req_addr;
  logic [7:0]  status_o;

  always #10 clk = ~clk;

  spi_nvram_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .prot_req(prot_req), .prot_req_sr(prot_req_sr),
    .prot_req_addr(prot_req_addr), .prot_grant(prot_grant), .status_o(status_o)
  );

  int n_chk = 0, n_bad = 0, req_cnt = 0;
  bit mode3 = 1'b0;
  logic [12:0] last_req_addr = '0;
  logic last_req_sr = 1'b0;
  logic [7:0] mdl [int];
  logic [7:0] wq [$];
  logic [7:0] rq [$];
  logic [7:0] v;

  always @(negedge clk) if (rst_n && prot_req) begin
    req_cnt++;
    last_req_addr = prot_req_addr;
    last_req_sr   = prot_req_sr;
  end

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, input int hold_bit, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      sck = 1'b0; si = tx[i]; #(H);
      if (i == hold_bit) begin
        hold_n = 1'b0; #(H);
        for (int k = 0; k < 2; k++) begin
          si = ~si; sck = 1'b1; #(H); sck = 1'b0; #(H);
        end
        chk("R11", "so_oe while paused", {31'd0, so_oe}, 32'd0);
        si = tx[i]; hold_n = 1'b1; #(H);
      end
      rx[i] = so;
      sck = 1'b1; #(H);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx);
    logic [7:0] d;
    xbits(tx, 8, -1, d);
  endtask

  task automatic sel();
    sck = mode3; #(H); cs_n = 1'b0; #(H);
  endtask

  task automatic desel();
    sck = mode3; #(H); cs_n = 1'b1; #(2*H);
  endtask

  task automatic cmd(input logic [7:0] op);
    sel(); xbyte(op); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    sel(); xbyte(C_RDSR); xbits(8'h00, 8, -1, s); desel();
  endtask

  task automatic wrsr(input logic [7:0] s);
    sel(); xbyte(C_WRSR); xbyte(s); desel();
  endtask

  task automatic wr_mem(input logic [15:0] a, input bit lands, input int hold_bit);
    logic [7:0] d;
    sel(); xbyte(C_WRITE); xbyte(a[15:8]); xbyte(a[7:0]);
    foreach (wq[i]) begin
      xbits(wq[i], 8, (i == 0) ? hold_bit : -1, d);
      if (lands) mdl[int'((a + 16'(i)) & 16'h1FFF)] = wq[i];
    end
    chk("R9", "so_oe during write data", {31'd0, so_oe}, 32'd0);
    desel();
  endtask

  task automatic rd_mem(input logic [15:0] a, input int n, input int hold_bit);
    logic [7:0] d;
    rq = {};
    sel(); xbyte(C_READ); xbyte(a[15:8]); xbyte(a[7:0]);
    for (int i = 0; i < n; i++) begin
      xbits($urandom_range(255, 0), 8, (i == 0) ? hold_bit : -1, d);
      rq.push_back(d);
    end
    desel();
  endtask

  task automatic chk_read(input string r, input logic [15:0] a, input int n, input int hold_bit);
    rd_mem(a, n, hold_bit);
    for (int i = 0; i < n; i++) begin
      int ix = int'((a + 16'(i)) & 16'h1FFF);
      if (mdl.exists(ix)) chk(r, $sformatf("read byte %0h", ix), {24'd0, rq[i]}, {24'd0, mdl[ix]});
    end
  endtask

  initial begin : main
    void'($urandom(32'd4242));
    repeat (8) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "status after reset", {24'd0, status_o}, 32'h00);
    chk("R12", "so_oe after reset", {31'd0, so_oe}, 32'd0);

    rdsr(v); chk("R1", "RDSR idle", {24'd0, v}, 32'h00);
    cmd(C_WREN); rdsr(v); chk("R1", "RDSR after set", {24'd0, v}, 32'h02);
    cmd(C_WRDI); rdsr(v); chk("R1", "RDSR after clear", {24'd0, v}, 32'h00);

    // base contents
    cmd(C_WREN);
    wq = {8'h11, 8'h22, 8'h33}; wr_mem(16'h0010, 1'b1, -1);
    rdsr(v); chk("R7", "WEL after write", {24'd0, v}, 32'h00);
    chk_read("R5", 16'h0010, 3, -1);
    cmd(C_WREN); wq = {8'h00, 8'h00}; wr_mem(16'h0040, 1'b1, -1);
    cmd(C_WREN); wq = {8'h00}; wr_mem(16'h0050, 1'b1, -1);

    // no enable flag: nothing lands
    wq = {8'h99}; wr_mem(16'h0010, 1'b0, -1);
    chk_read("R5", 16'h0010, 1, -1);

    // grant withheld
    cmd(C_WREN); prot_grant = 1'b0; req_cnt = 0;
    wq = {8'h77}; wr_mem(16'h0011, 1'b0, -1);
    prot_grant = 1'b1;
    chk("R8", "request count", req_cnt, 1);
    chk("R8", "request addr", {19'd0, last_req_addr}, 32'h0011);
    chk("R8", "request target", {31'd0, last_req_sr}, 32'd0);
    chk_read("R8", 16'h0011, 1, -1);

    // high address bits dropped
    cmd(C_WREN); wq = {8'h5A}; wr_mem(16'hE005, 1'b1, -1);
    chk_read("R3", 16'h0005, 1, -1);

    // wrap at the top
    cmd(C_WREN); wq = {8'hC1, 8'hC2, 8'hC3, 8'hC4}; wr_mem(16'h1FFE, 1'b1, -1);
    chk_read("R4", 16'h1FFE, 4, -1);
    chk_read("R4", 16'h0000, 2, -1);

    // partial byte discarded
    cmd(C_WREN);
    sel(); xbyte(C_WRITE); xbyte(8'h00); xbyte(8'h40); xbyte(8'hD1);
    xbits(8'hEE, 4, -1, v); desel();
    mdl[32'h40] = 8'hD1;
    chk_read("R5", 16'h0040, 2, -1);

    // one command per select
    sel(); xbyte(C_WREN); xbyte(C_WRITE); xbyte(8'h00); xbyte(8'h50); xbyte(8'hAB); desel();
    rdsr(v); chk("R2", "WEL kept after ignored bytes", {24'd0, v}, 32'h02);
    chk_read("R2", 16'h0050, 1, -1);
    cmd(C_WRDI);

    // unknown command
    sel(); xbyte(8'hFF); xbyte(C_WREN);
    chk("R2", "so_oe after unknown", {31'd0, so_oe}, 32'd0);
    desel();
    rdsr(v); chk("R2", "RDSR after unknown", {24'd0, v}, 32'h00);

    // control byte write
    cmd(C_WREN); req_cnt = 0; wrsr(8'hFF);
    chk("R8", "status request target", {31'd0, last_req_sr}, 32'd1);
    rdsr(v); chk("R6", "control byte", {24'd0, v}, 32'h8C);
    chk("R7", "status_o port", {24'd0, status_o}, 32'h8C);
    cmd(C_WREN); prot_grant = 1'b0; wrsr(8'h00); prot_grant = 1'b1;
    rdsr(v); chk("R8", "control byte with grant low", {24'd0, v}, 32'h8C);
    wrsr(8'h00);
    rdsr(v); chk("R6", "control write without flag", {24'd0, v}, 32'h8C);
    cmd(C_WREN); wrsr(8'h00);
    rdsr(v); chk("R6", "control cleared", {24'd0, v}, 32'h00);

    // idle-high clock
    mode3 = 1'b1;
    cmd(C_WREN); wq = {8'h3E, 8'h4F, 8'h60}; wr_mem(16'h0123, 1'b1, -1);
    chk_read("R10", 16'h0123, 3, -1);
    rdsr(v); chk("R10", "RDSR idle high", {24'd0, v}, 32'h00);
    mode3 = 1'b0;

    // pause in a write and in a read
    cmd(C_WREN); wq = {8'h3C, 8'hC3}; wr_mem(16'h0100, 1'b1, 3);
    chk_read("R11", 16'h0100, 2, 4);

    // random bursts
    for (int t = 0; t < 20; t++) begin
      logic [15:0] a;
      int len;
      a = 16'($urandom);
      len = 1 + int'($urandom_range(4, 0));
      wq = {};
      for (int k = 0; k < len; k++) wq.push_back(8'($urandom));
      mode3 = bit'($urandom_range(1, 0));
      cmd(C_WREN);
      wr_mem(a, 1'b1, -1);
      chk_read("R4", a, len, -1);
    end
    mode3 = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule